// File: doc/BRIEF.md
# Copy Generation Management Data Line Generator

This block produces the serial bit stream that carries copy generation management data on one line per field of an interlaced NTSC picture. On the line that opens each field's insertion line, it qualifies the line against the field parity and the per-field enables. It then captures a 20-bit data word and, after a programmable delay, shifts out a short reference pattern followed by the word, one bit every fixed number of pixel clocks.

The word holds 14 payload bits and a 6-bit check tail. The tail is either copied from the supplied word or computed in hardware from the payload, selected by a control input. The outputs are a per-clock insert-valid flag and a digital bit level. A later stage turns these into video amplitude.

The caller pulses `line_start` for one clock at each line's sync edge. `line_num` and `field_odd` are valid in that same cycle.

Top module: `cgms_line_gen`

## Requirements
- R1: After reset, `ins_valid` and `ins_bit` are both 0 and stay 0 until a qualifying line starts.
- R2: A line qualifies when `line_num`=20 with `field_odd`=1 and `odd_en`=1, or when `line_num`=283 with `field_odd`=0 and `even_en`=1.
- R3: On a non-qualifying line, `ins_valid` stays 0 for the whole line. This covers a wrong line number, the right number in the other field's parity, and a cleared enable. `ins_bit` is 0 whenever `ins_valid` is 0.
- R4: Counting the cycle after the `line_start` edge as cycle 0, `ins_valid` is 1 exactly in cycles `start_off` through `start_off`+285 (22 bits of 13 clocks each).
- R5: The emitted frame order is a 1, then a 0, then word bits C0 through C19, least significant first. Cn is bit n of the captured word.
- R6: Every frame bit is held on `ins_bit` for exactly 13 consecutive clocks.
- R7: With `crc_auto`=1, C0..C13 come from `cgms_data`[13:0]. C(14+j) is bit j of a 6-bit shift register, preset to all ones and run over C0 first to C13. For each input bit b, the feedback is f = b xor r[5], and the register becomes (r shifted left by one) xor (f ? 6'b000011 : 0). This is polynomial x^6+x+1.
- R8: With `crc_auto`=0, C14..C19 are `cgms_data`[19:14] unchanged.
- R9: The data word and `crc_auto` are sampled only in the `line_start` cycle. Changes to either afterwards do not alter the frame in progress.
- R10: With `start_off`=0, the first reference bit appears in cycle 0.
- R11: A `line_start` that arrives during a frame ends that frame. If the new line does not qualify, `ins_valid` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse at a line's sync edge |
| line_num | input | 10 | Line number, valid with line_start |
| field_odd | input | 1 | 1 in odd fields, valid with line_start |
| cgms_data | input | 20 | Data word, bit n is Cn |
| odd_en | input | 1 | Enable insertion in odd fields |
| even_en | input | 1 | Enable insertion in even fields |
| crc_auto | input | 1 | 1 computes C14..C19 from the payload |
| start_off | input | 8 | Delay in clocks from line start to the first bit |
| ins_valid | output | 1 | High while the frame occupies the line |
| ins_bit | output | 1 | Current frame bit level |

## Verification
The bench compares every clock of each line against a model built from the requirements. Its targets are the window edges at offset zero and at a large offset, where an off-by-one counter would shift the frame or cut it to 285 clocks. It uses payloads whose check tail differs from the supplied tail, so a swapped or unsourced tail shows up. It rewrites the data mid-line; a design that reads the register live would emit a mixed word. It also sends line 20 in an even field and line 283 in an odd one, aborts a frame with a fresh line pulse, and clears each enable alone. A parity mix-up or a missed abort would put data on a wrong line.

// File: rtl/cgms_pkg.sv
package cgms_pkg;

    localparam int WORD_W  = 20;
    localparam int PAY_W   = 14;
    localparam int CHK_W   = WORD_W - PAY_W;
    localparam int REF_W   = 2;
    localparam int FRAME_W = WORD_W + REF_W;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_WAIT = 2'd1,
        GEN_SEND = 2'd2
    } gen_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              hit;
    } line_cap_t;

    // One serial step of the x^6+x+1 check register.
    function automatic logic [CHK_W-1:0] chk_step(input logic [CHK_W-1:0] r,
                                                  input logic b);
        logic fb;
        fb = b ^ r[CHK_W-1];
        return {r[CHK_W-2:1], r[0] ^ fb, fb};
    endfunction

endpackage

// File: rtl/cgms_chk6.sv
module cgms_chk6
    import cgms_pkg::*;
#(
    parameter int N_BITS = PAY_W
) (
    input  logic [N_BITS-1:0] payload,
    output logic [CHK_W-1:0]  chk
);
    logic [CHK_W-1:0] stage [0:N_BITS];

    assign stage[0] = '1;

    for (genvar i = 0; i < N_BITS; i++) begin : g_step
        assign stage[i+1] = chk_step(stage[i], payload[i]);
    end

    assign chk = stage[N_BITS];
endmodule

// File: rtl/cgms_line_qual.sv
module cgms_line_qual
    import cgms_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int ODD_LINE  = 20,
    parameter int EVEN_LINE = 283
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_odd,
    input  logic              odd_en,
    input  logic              even_en,
    input  logic              crc_auto,
    input  logic [WORD_W-1:0] data_in,
    output line_cap_t         cap
);
    logic [CHK_W-1:0] chk;
    logic [WORD_W-1:0] word_next;
    logic hit_next;

    cgms_chk6 #(.N_BITS(PAY_W)) u_chk (
        .payload(data_in[PAY_W-1:0]),
        .chk    (chk)
    );

    always_comb begin
        word_next = crc_auto ? {chk, data_in[PAY_W-1:0]} : data_in;
        hit_next  = (field_odd  && odd_en  && line_num == LINE_W'(ODD_LINE)) ||
                    (!field_odd && even_en && line_num == LINE_W'(EVEN_LINE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else if (line_start) begin
            cap.word <= word_next;
            cap.hit  <= hit_next;
        end
    end
endmodule

// File: rtl/cgms_bit_timer.sv
module cgms_bit_timer
    import cgms_pkg::*;
#(
    parameter int OFF_W    = 8,
    parameter int BIT_CLKS = 13,
    parameter int N_BITS   = FRAME_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        line_start,
    input  logic                        arm,
    input  logic [OFF_W-1:0]            start_off,
    output logic                        sending,
    output logic [$clog2(N_BITS)-1:0]   bit_idx,
    output logic [$clog2(BIT_CLKS)-1:0] sub_cnt
);
    localparam int IDX_W = $clog2(N_BITS);
    localparam int SUB_W = $clog2(BIT_CLKS);

    gen_state_t state;
    logic [OFF_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= GEN_IDLE;
            wait_cnt <= '0;
            bit_idx  <= '0;
            sub_cnt  <= '0;
        end else if (line_start) begin
            bit_idx  <= '0;
            sub_cnt  <= '0;
            wait_cnt <= start_off - OFF_W'(1);
            if (!arm)                  state <= GEN_IDLE;
            else if (start_off == '0)  state <= GEN_SEND;
            else                       state <= GEN_WAIT;
        end else begin
            case (state)
                GEN_WAIT: begin
                    if (wait_cnt == '0) state <= GEN_SEND;
                    else                wait_cnt <= wait_cnt - OFF_W'(1);
                end
                GEN_SEND: begin
                    if (sub_cnt == SUB_W'(BIT_CLKS - 1)) begin
                        sub_cnt <= '0;
                        if (bit_idx == IDX_W'(N_BITS - 1)) begin
                            bit_idx <= '0;
                            state   <= GEN_IDLE;
                        end else begin
                            bit_idx <= bit_idx + IDX_W'(1);
                        end
                    end else begin
                        sub_cnt <= sub_cnt + SUB_W'(1);
                    end
                end
                default: state <= GEN_IDLE;
            endcase
        end
    end

    assign sending = (state == GEN_SEND);

    // R6
    sub_range_chk: assert property (@(posedge clk) disable iff (rst)
        sub_cnt < SUB_W'(BIT_CLKS));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        sending |-> bit_idx < IDX_W'(N_BITS));
endmodule

// File: rtl/cgms_line_gen.sv
module cgms_line_gen
    import cgms_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int OFF_W     = 8,
    parameter int BIT_CLKS  = 13,
    parameter int ODD_LINE  = 20,
    parameter int EVEN_LINE = 283
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_odd,
    input  logic [19:0]       cgms_data,
    input  logic              odd_en,
    input  logic              even_en,
    input  logic              crc_auto,
    input  logic [OFF_W-1:0]  start_off,
    output logic              ins_valid,
    output logic              ins_bit
);
    localparam int IDX_W = $clog2(FRAME_W);
    localparam int SUB_W = $clog2(BIT_CLKS);

    line_cap_t cap;
    logic hit_now;
    logic sending;
    logic [IDX_W-1:0] bit_idx;
    logic [SUB_W-1:0] sub_cnt;
    logic [FRAME_W-1:0] frame;

    cgms_line_qual #(
        .LINE_W(LINE_W), .ODD_LINE(ODD_LINE), .EVEN_LINE(EVEN_LINE)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .line_num  (line_num),
        .field_odd (field_odd),
        .odd_en    (odd_en),
        .even_en   (even_en),
        .crc_auto  (crc_auto),
        .data_in   (cgms_data),
        .cap       (cap)
    );

    assign hit_now = (field_odd  && odd_en  && line_num == LINE_W'(ODD_LINE)) ||
                     (!field_odd && even_en && line_num == LINE_W'(EVEN_LINE));

    cgms_bit_timer #(
        .OFF_W(OFF_W), .BIT_CLKS(BIT_CLKS), .N_BITS(FRAME_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .arm       (hit_now),
        .start_off (start_off),
        .sending   (sending),
        .bit_idx   (bit_idx),
        .sub_cnt   (sub_cnt)
    );

    assign frame     = {cap.word, 1'b0, 1'b1};
    assign ins_valid = sending;
    assign ins_bit   = sending & frame[bit_idx];

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !$past(line_start)) |-> $stable(cap.word));

    // R3
    no_hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (line_start && !hit_now) |=> !ins_valid);

    // R6
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && sub_cnt != '0) |-> $stable(ins_bit));

    // R3
    bit_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !ins_valid |-> !ins_bit);

    // R2
    hit_match_chk: assert property (@(posedge clk) disable iff (rst)
        ins_valid |-> cap.hit);
endmodule

// File: tb/cgms_line_gen_tb.sv
module cgms_line_gen_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_start = 1'b0;
    logic [9:0] line_num = '0;
    logic field_odd = 1'b0;
    logic [19:0] cgms_data = '0;
    logic odd_en = 1'b0;
    logic even_en = 1'b0;
    logic crc_auto = 1'b0;
    logic [7:0] start_off = '0;
    logic ins_valid, ins_bit;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cgms_line_gen u_dut (
        .clk(clk), .rst(rst), .line_start(line_start), .line_num(line_num),
        .field_odd(field_odd), .cgms_data(cgms_data), .odd_en(odd_en),
        .even_en(even_en), .crc_auto(crc_auto), .start_off(start_off),
        .ins_valid(ins_valid), .ins_bit(ins_bit)
    );

    function automatic logic [5:0] ref_chk(input logic [13:0] p);
        logic [5:0] r = 6'h3F;
        for (int i = 0; i < 14; i++) begin
            logic f;
            f = p[i] ^ r[5];
            r = r << 1;
            if (f) r = r ^ 6'b000011;
        end
        return r;
    endfunction

    // Drives one line and compares every clock against the model.
    task automatic run_line(input string req, input logic [9:0] ln, input logic odd,
                            input logic [19:0] d, input logic eo, input logic ee,
                            input logic ca, input logic [7:0] off, input bit mid_change);
        logic [19:0] w;
        logic [21:0] fr;
        bit hit;
        int bad = 0;
        logic ev, eb;
        hit = (odd && eo && ln == 10'd20) || (!odd && ee && ln == 10'd283);
        w = ca ? {ref_chk(d[13:0]), d[13:0]} : d;
        fr = {w, 1'b0, 1'b1};
        @(negedge clk);
        line_num = ln; field_odd = odd; cgms_data = d; odd_en = eo; even_en = ee;
        crc_auto = ca; start_off = off; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int k = 0; k < int'(off) + 300; k++) begin
            ev = hit && k >= int'(off) && k < int'(off) + 286;
            eb = ev ? fr[(k - int'(off)) / 13] : 1'b0;
            if (ins_valid !== ev || ins_bit !== eb) begin
                if (bad == 0)
                    $display("FAIL %s cycle %0d: valid/bit=%b%b expected %b%b",
                             req, k, ins_valid, ins_bit, ev, eb);
                bad++;
            end
            if (mid_change && k == 40) begin
                cgms_data = ~d; crc_auto = ~ca;
            end
            @(negedge clk);
        end
        n_tests++;
        if (bad != 0) n_fail++;
    endtask

    task automatic check_reset();
        for (int k = 0; k < 20; k++) begin
            n_tests++;
            if (ins_valid !== 1'b0 || ins_bit !== 1'b0) begin
                n_fail++;
                $display("FAIL R1: valid/bit=%b%b expected 00", ins_valid, ins_bit);
            end
            @(negedge clk);
        end
    endtask

    // R11: abort a frame with a non-qualifying line pulse
    task automatic check_abort();
        @(negedge clk);
        line_num = 10'd20; field_odd = 1'b1; odd_en = 1'b1; cgms_data = 20'hFFFFF;
        crc_auto = 1'b0; start_off = 8'd2; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (60) @(negedge clk);
        n_tests++;
        if (ins_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R11: mid-frame valid=%b expected 1", ins_valid);
        end
        line_num = 10'd21; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (ins_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R11: cycle %0d valid=%b expected 0", k, ins_valid);
                break;
            end
            @(negedge clk);
        end
        n_tests++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset();                                                             // R1
        run_line("R2 R5 R8 odd line", 10'd20, 1'b1, 20'hA5C3B, 1, 0, 0, 8'd10, 0);
        run_line("R2 R6 even line",   10'd283, 1'b0, 20'h3C96E, 0, 1, 0, 8'd7, 0);
        run_line("R7 check tail",     10'd20, 1'b1, 20'h00000, 1, 1, 1, 8'd5, 0);
        run_line("R7 check tail b",   10'd283, 1'b0, 20'hF2D5A, 1, 1, 1, 8'd3, 0);
        run_line("R7 check tail c",   10'd20, 1'b1, 20'h03FFF, 1, 0, 1, 8'd9, 0);
        run_line("R10 zero offset",   10'd20, 1'b1, 20'h5A5A5, 1, 0, 0, 8'd0, 0);
        run_line("R4 max offset",     10'd283, 1'b0, 20'h12345, 0, 1, 0, 8'd255, 0);
        run_line("R9 mid-line write", 10'd20, 1'b1, 20'h6B1E4, 1, 0, 1, 8'd4, 1);
        run_line("R3 odd disabled",   10'd20, 1'b1, 20'hFFFFF, 0, 1, 0, 8'd4, 0);
        run_line("R3 even disabled",  10'd283, 1'b0, 20'hFFFFF, 1, 0, 0, 8'd4, 0);
        run_line("R3 wrong parity a", 10'd20, 1'b0, 20'hFFFFF, 1, 1, 0, 8'd4, 0);
        run_line("R3 wrong parity b", 10'd283, 1'b1, 20'hFFFFF, 1, 1, 0, 8'd4, 0);
        run_line("R3 other line",     10'd21, 1'b1, 20'hFFFFF, 1, 1, 0, 8'd4, 0);
        check_abort();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: run did not end, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule